// File: doc/BRIEF.md
# Cascaded FIFO Slices with Circulating Read and Write Ownership

This block joins several identical FIFO slices into one deeper FIFO. Each slice has its own small storage array and its own read and write pointers, but no slice is addressed from outside. Ownership moves instead: exactly one slice holds the write token and exactly one holds the read token. A write strobe is taken only by the slice holding the write token, and a read strobe only by the slice holding the read token. When the owning slice uses its highest storage location, it raises a one-clock pulse on its expansion output. The pulse is tagged as a read or write handoff, and the next slice in the ring takes the matching token on that same edge.

After reset, the slice whose first-load input is low holds both tokens, and every slice's pointers are at location zero. The slice outputs are joined in a ring: each expansion output feeds the next slice's expansion input, and the last feeds the first. Outside the slices, the wrapper forms the combined full flag as the AND of the slice full flags and the combined empty flag as the AND of the slice empty flags. Read data is the OR of the slice outputs, and a slice keeps its output at zero unless it has just completed a read. With a single slice the token logic is bypassed and the slice works as a plain standalone FIFO.

Top module: `chain_fifo`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, empty is 1, full is 0 and rd_valid is 0. Words stored before a reset are discarded.
- R2: Words come out in the order they were accepted, including runs longer than one slice (DEPTH words), so the data spans every slice in sequence.
- R3: full is 1 exactly when NSLICE*DEPTH words are stored. A write strobe while full is ignored and its word is never read back. A write and a read in the same cycle while full accept only the read.
- R4: empty is 1 exactly when no word is stored. A read strobe while empty produces no rd_valid.
- R5: An accepted read (rd_en high, empty low at the clock edge) gives rd_valid = 1 and the word on rd_data in the cycle after that edge. rd_valid is 0 in every other cycle.
- R6: Write ownership passes to the next slice on the same edge at which the owner writes its last location, so a continuous write stream loses no word at slice boundaries. Read ownership passes the same way. Exactly one slice holds each token at all times, and a handoff pulse is one cycle wide and carries one strobe type.
- R7: Ownership circulates around the ring: after the last slice hands off, the first slice owns the token again. A stream far longer than the total capacity keeps its order.
- R8: A read and a write in the same cycle, with the FIFO neither empty nor full, both take effect.
- R9: rd_data is all zeros in every cycle in which rd_valid is 0, and at most one slice drives read data at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rd_data | output | WIDTH | Word read, valid with rd_valid, otherwise zero |
| rd_valid | output | 1 | High the cycle after an accepted read |
| full | output | 1 | All slices full |
| empty | output | 1 | All slices empty |

## Verification
The assertions assume that wr_en and rd_en may be raised in any cycle, including while full or empty, and that the block itself must refuse such strobes. Inputs are expected to change only away from the rising clock edge, DEPTH is at least two, and the slices form a single ring with exactly one first-load slice. The bench changes every input on the falling edge and deliberately pushes strobes into the full and empty states, so the guard logic is exercised without leaving those assumptions.

// File: rtl/chain_pkg.sv
package chain_pkg;

  // Handoff line between neighbouring slices
  typedef struct packed {
    logic pulse;   // one-cycle handoff event
    logic is_rd;   // 1: read token moves, 0: write token moves
  } xline_t;

  // Pointer advance with wrap at the slice depth
  function automatic int unsigned wrap_next(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // True when a pointer addresses the highest location
  function automatic logic at_last(int unsigned p, int unsigned depth);
    return p == depth - 1;
  endfunction

  // Ring neighbour that feeds slice i
  function automatic int unsigned ring_prev(int unsigned i, int unsigned n);
    return (i == 0) ? n - 1 : i - 1;
  endfunction

endpackage

// File: rtl/chain_slice_mem.sv
module chain_slice_mem #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 9,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/chain_slice.sv
module chain_slice
  import chain_pkg::*;
#(
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned WIDTH      = 9,
  parameter bit          STANDALONE = 1'b0,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_load_n,
  input  xline_t           xin,
  output xline_t           xout,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_q,
  output logic             rd_q_vld,
  output logic             full,
  output logic             empty,
  output logic             wtok_o,
  output logic             rtok_o
);
  logic          wtok, rtok;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic [WIDTH-1:0] mem_rd;

  // Named internal events
  logic wr_own, rd_own, wr_fire, rd_fire, wr_last, rd_last;

  assign wr_own  = STANDALONE ? 1'b1 : wtok;
  assign rd_own  = STANDALONE ? 1'b1 : rtok;
  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign wr_fire = wr_en && wr_own && !full;
  assign rd_fire = rd_en && rd_own && !empty;
  assign wr_last = wr_fire && at_last(32'(wptr), DEPTH);
  assign rd_last = rd_fire && at_last(32'(rptr), DEPTH);

  assign xout.pulse = !STANDALONE && (wr_last || rd_last);
  assign xout.is_rd = rd_last;
  assign wtok_o     = wr_own;
  assign rtok_o     = rd_own;

  // Token ownership: lost on own last-location access, gained from neighbour
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wtok <= !first_load_n;
      rtok <= !first_load_n;
    end else begin
      if (wr_last)                        wtok <= 1'b0;
      else if (xin.pulse && !xin.is_rd)   wtok <= 1'b1;
      if (rd_last)                        rtok <= 1'b0;
      else if (xin.pulse && xin.is_rd)    rtok <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      rd_q     <= '0;
      rd_q_vld <= 1'b0;
    end else begin
      if (wr_fire) wptr <= AW'(wrap_next(32'(wptr), DEPTH));
      if (rd_fire) rptr <= AW'(wrap_next(32'(rptr), DEPTH));
      cnt      <= cnt + CW'(wr_fire) - CW'(rd_fire);
      rd_q     <= rd_fire ? mem_rd : '0;
      rd_q_vld <= rd_fire;
    end
  end

  chain_slice_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wptr),
    .wdata (wr_data),
    .raddr (rptr),
    .rdata (mem_rd)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> $stable(wptr)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> !rd_q_vld); // R4
  AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_own) |=> $stable(wptr)); // R6
  AST_FOREIGN_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_own) |=> !rd_q_vld); // R9
  AST_XO_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_last && rd_last)); // R6
  AST_XO_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (xout.pulse && !xout.is_rd) |=> !(xout.pulse && !xout.is_rd)); // R6
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_q_vld |-> (rd_q == '0)); // R9
endmodule

// File: rtl/chain_fifo.sv
module chain_fifo
  import chain_pkg::*;
#(
  parameter int unsigned NSLICE = 3,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned WIDTH  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             full,
  output logic             empty
);
  localparam bit SOLO = (NSLICE == 1);

  xline_t            xl    [NSLICE];
  logic [WIDTH-1:0]  q_s   [NSLICE];
  logic [NSLICE-1:0] vld_s, full_s, empty_s, wtok, rtok;

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    chain_slice #(.DEPTH(DEPTH), .WIDTH(WIDTH), .STANDALONE(SOLO)) u_slice (
      .clk          (clk),
      .rst_n        (rst_n),
      .first_load_n (i != 0),
      .xin          (xl[ring_prev(i, NSLICE)]),
      .xout         (xl[i]),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .rd_en        (rd_en),
      .rd_q         (q_s[i]),
      .rd_q_vld     (vld_s[i]),
      .full         (full_s[i]),
      .empty        (empty_s[i]),
      .wtok_o       (wtok[i]),
      .rtok_o       (rtok[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSLICE; i++) rd_data |= q_s[i];
  end

  assign rd_valid = |vld_s;
  assign full     = &full_s;
  assign empty    = &empty_s;

  AST_ONE_WR_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wtok) == 1); // R6
  AST_ONE_RD_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rtok) == 1); // R6
  AST_SINGLE_READER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vld_s)); // R9
  AST_EMPTY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> !rd_valid); // R4
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R3
endmodule

// File: tb/sim_chain_fifo.sv
module sim_chain_fifo;
  localparam int PERIOD = 10;
  localparam int NSLICE = 3;
  localparam int DEPTH  = 4;
  localparam int WIDTH  = 9;
  localparam int CAP    = NSLICE * DEPTH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic rd_valid, full, empty;

  int checks = 0, failures = 0;
  logic [WIDTH-1:0] seed = 9'd1;
  logic [WIDTH-1:0] model [$];

  always #(PERIOD/2) clk = ~clk;

  chain_fifo #(.NSLICE(NSLICE), .DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .full(full), .empty(empty)
  );

  typedef struct packed {
    logic       w;
    logic       r;
    logic [7:0] n;
    logic [3:0] tg;
  } row_t;

  // Stimulus rows: strobes, repeat count, requirement code
  localparam row_t ROWS [9] = '{
    '{1'b1, 1'b0, 8'(CAP + 3), 4'd3},   // fill past capacity
    '{1'b1, 1'b1, 8'd3,        4'd3},   // read+write while full
    '{1'b0, 1'b1, 8'(CAP + 2), 4'd2},   // drain past empty, order across slices
    '{1'b1, 1'b1, 8'd5,        4'd8},   // simultaneous from empty
    '{1'b1, 1'b0, 8'd6,        4'd6},   // cross a slice boundary
    '{1'b1, 1'b1, 8'd40,       4'd7},   // long stream around the ring
    '{1'b0, 1'b1, 8'(CAP + 1), 4'd4},   // drain to empty
    '{1'b0, 1'b0, 8'd2,        4'd9},   // idle output
    '{1'b1, 1'b0, 8'(CAP),     4'd7}    // fill exactly after wrap
  };

  function automatic string tag_name(logic [3:0] c);
    case (c)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tg, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tg, what, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input string tg);
    logic acc_w, acc_r;
    logic [WIDTH-1:0] ed;
    @(negedge clk);
    wr_en = w; rd_en = r; wr_data = seed; seed = seed + 1'b1;
    acc_w = w && (model.size() < CAP);
    acc_r = r && (model.size() > 0);
    ed = acc_r ? model.pop_front() : '0;
    if (acc_w) model.push_back(wr_data);
    @(posedge clk); #1;
    chk(rd_valid == acc_r, "R5", "rd_valid", int'(rd_valid), int'(acc_r));
    if (acc_r) chk(rd_data == ed, tg, "rd_data", int'(rd_data), int'(ed));
    else       chk(rd_data == '0, "R9", "idle rd_data", int'(rd_data), 0);
    chk(full == (model.size() == CAP), "R3", "full", int'(full), int'(model.size() == CAP));
    chk(empty == (model.size() == 0), "R4", "empty", int'(empty), int'(model.size() == 0));
  endtask

  task automatic reset_flags_check();
    chk(empty == 1'b1, "R1", "empty in reset", int'(empty), 1);
    chk(full == 1'b0, "R1", "full in reset", int'(full), 0);
    chk(rd_valid == 1'b0, "R1", "rd_valid in reset", int'(rd_valid), 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: state during and right after reset
    repeat (3) @(negedge clk);
    reset_flags_check();
    rst_n = 1'b1;
    @(posedge clk); #1;
    reset_flags_check();

    // Table walk
    for (int k = 0; k < 9; k++) begin
      for (int j = 0; j < int'(ROWS[k].n); j++)
        cyc(ROWS[k].w, ROWS[k].r, tag_name(ROWS[k].tg));
    end
    cyc(1'b0, 1'b0, "R9");

    // R1: reset mid-stream discards stored words
    for (int j = 0; j < 5; j++) cyc(1'b1, 1'b0, "R1");
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; rst_n = 1'b0;
    model.delete();
    #1;
    reset_flags_check();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    reset_flags_check();
    for (int j = 0; j < 3; j++) cyc(1'b1, 1'b0, "R1");
    for (int j = 0; j < 4; j++) cyc(1'b0, 1'b1, "R1");

    // R6: exact slice-sized bursts, write then read, twice around
    for (int p = 0; p < 2 * NSLICE; p++) begin
      for (int j = 0; j < DEPTH; j++) cyc(1'b1, 1'b0, "R6");
      for (int j = 0; j < DEPTH; j++) cyc(1'b0, 1'b1, "R6");
    end

    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule